// File: doc/BRIEF.md
# Interrupt and Halt Controller

This block decides when an 8-bit processor's control unit leaves normal execution to service an interrupt, and it manages the halted state. It watches two active-low interrupt inputs. The non-maskable one is edge-triggered. The maskable one is a level, gated by a software enable flag. The block samples them only at defined acceptance points: the end of an instruction, or any cycle while halted. A pending bus request defers acceptance of both.

Accepting a maskable interrupt starts an acknowledge window. During the window the opcode-fetch strobe and the I/O strobe are driven low together, and the responding device's vector byte is captured from the data bus on the last clock of the window. Accepting a non-maskable interrupt produces a one-cycle service pulse and no bus window.

A halt strobe holds the processor in a halted state. In that state the halt status is low, and a request tells the sequencer to keep fetching NOPs so that memory refresh continues. Accepting an interrupt ends the halted state.

Top module: `intr_halt_ctl`

## Requirements
- R1: While reset is low and on the first cycle after it, halt_n=1, nop_force=0, m1_n=1, iorq_n=1, svc_nmi=0, vec_valid=0 and vector=0. The enable flag is cleared and any latched non-maskable edge is discarded.
- R2: The enable flag is set by ie_set and cleared by ie_clr; when both are high, clearing wins. A maskable request (int_req_n=0) is accepted only at an acceptance point, only while the flag is set, and only when no non-maskable edge is pending.
- R3: Accepting a maskable request drives m1_n and iorq_n low together for exactly ACK_CYCLES cycles, starting the cycle after the acceptance edge. iorq_n is never low while m1_n is high.
- R4: The data_in value present at the last clock edge of the acknowledge window is loaded into vector, and vec_valid is high for the single following cycle. vector does not change at any other time.
- R5: A falling edge on nmi_n is latched. It is accepted at the next acceptance point regardless of the enable flag and ahead of a maskable request, and svc_nmi is pulsed high for one cycle. Holding nmi_n low produces only one pulse.
- R6: While bus_req=1, no interrupt of either kind is accepted. A pending non-maskable edge stays latched until a later acceptance point.
- R7: halt_exec at a cycle with no acceptance drives halt_n low and nop_force high. While halted, every cycle is an acceptance point, with no instr_end needed. halt_n returns high the cycle after an acceptance.
- R8: Accepting either kind of interrupt clears the enable flag. A second maskable request is ignored until ie_set is given again.
- R9: While halted with the enable flag clear, a low int_req_n neither releases the halt nor starts an acknowledge window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_req_n | input | 1 | Maskable interrupt request, active low, level |
| nmi_n | input | 1 | Non-maskable interrupt, active low, falling-edge |
| halt_exec | input | 1 | Strobe: halt instruction executed |
| instr_end | input | 1 | Strobe: current instruction finishes |
| ie_set | input | 1 | Set the interrupt enable flag |
| ie_clr | input | 1 | Clear the interrupt enable flag |
| bus_req | input | 1 | Pending external bus request, defers acceptance |
| data_in | input | VEC_W | Data bus, carries the vector during acknowledge |
| halt_n | output | 1 | Halted status, active low |
| nop_force | output | 1 | Sequencer must fetch NOPs (refresh continues) |
| m1_n | output | 1 | Fetch-cycle strobe, low during acknowledge |
| iorq_n | output | 1 | I/O strobe, low during acknowledge |
| svc_nmi | output | 1 | One-cycle pulse: non-maskable interrupt accepted |
| vec_valid | output | 1 | One-cycle pulse: vector just captured |
| vector | output | VEC_W | Captured interrupt vector, held |

## Verification
The embedded properties check cycle-level invariants on every clock. The I/O strobe never appears without the fetch strobe, and an acknowledge window never opens while the enable flag is clear or just after a bus request. The vector changes only together with its valid pulse, the service pulse never lasts two cycles, and the halt status rises only together with an acceptance. Other behaviour needs the bench's scenarios and its per-cycle reference model: the exact length of the window, the set/clear priority of the enable flag, the single pulse for a held non-maskable level, deferral under bus request, and that a second request is ignored after acceptance.

// File: rtl/intr_halt_ctl.sv
module intr_halt_ctl #(
  parameter int ACK_CYCLES = 3,
  parameter int VEC_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_req_n,
  input  logic             nmi_n,
  input  logic             halt_exec,
  input  logic             instr_end,
  input  logic             ie_set,
  input  logic             ie_clr,
  input  logic             bus_req,
  input  logic [VEC_W-1:0] data_in,
  output logic             halt_n,
  output logic             nop_force,
  output logic             m1_n,
  output logic             iorq_n,
  output logic             svc_nmi,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vector
);
  localparam int CW = (ACK_CYCLES > 1) ? $clog2(ACK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACK_CYCLES - 1);

  logic             nmi_q, nmi_pend, ie_q, halted_q, in_ack, svc_q, vv_q;
  logic [CW-1:0]    ack_cnt;
  logic [VEC_W-1:0] vec_q;

  wire nmi_fall = nmi_q & ~nmi_n;
  wire point    = (instr_end | halted_q) & ~in_ack & ~bus_req;
  wire take_nmi = point & nmi_pend;
  wire take_int = point & ~nmi_pend & ~int_req_n & ie_q;
  wire take     = take_nmi | take_int;
  wire ack_last = in_ack && (ack_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
      ie_q     <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      nmi_q    <= nmi_n;
      nmi_pend <= nmi_fall | (nmi_pend & ~take_nmi);
      if (take || ie_clr) ie_q <= 1'b0;
      else if (ie_set)    ie_q <= 1'b1;
      if (take)           halted_q <= 1'b0;
      else if (halt_exec) halted_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ack  <= 1'b0;
      ack_cnt <= '0;
      vec_q   <= '0;
      vv_q    <= 1'b0;
      svc_q   <= 1'b0;
    end else begin
      svc_q <= take_nmi;
      vv_q  <= ack_last;
      if (take_int) begin
        in_ack  <= 1'b1;
        ack_cnt <= '0;
      end else if (ack_last) begin
        in_ack  <= 1'b0;
        vec_q   <= data_in;
      end else if (in_ack) begin
        ack_cnt <= ack_cnt + 1'b1;
      end
    end
  end

  assign halt_n    = ~halted_q;
  assign nop_force = halted_q;
  assign m1_n      = ~in_ack;
  assign iorq_n    = ~in_ack;
  assign svc_nmi   = svc_q;
  assign vec_valid = vv_q;
  assign vector    = vec_q;

  assert_iorq_needs_m1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !iorq_n |-> !m1_n);
  assert_ack_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(m1_n) |-> $past(ie_q));
  assert_ack_not_after_busreq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(m1_n) |-> !$past(bus_req));
  assert_vector_only_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vector) |-> vec_valid);
  assert_single_nmi_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_nmi |=> !svc_nmi);
  assert_halt_release_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_n) |-> (!m1_n || svc_nmi));
endmodule

// File: tb/sim_intr_halt_ctl.sv
module sim_intr_halt_ctl;
  localparam int ACK = 3;
  logic clk = 0, rst_n = 0;
  logic int_req_n = 1, nmi_n = 1, halt_exec = 0, instr_end = 0;
  logic ie_set = 0, ie_clr = 0, bus_req = 0;
  logic [7:0] data_in = 8'h00;
  logic halt_n, nop_force, m1_n, iorq_n, svc_nmi, vec_valid;
  logic [7:0] vector;
  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intr_halt_ctl #(.ACK_CYCLES(ACK), .VEC_W(8)) u0 (
    .clk, .rst_n, .int_req_n, .nmi_n, .halt_exec, .instr_end, .ie_set, .ie_clr,
    .bus_req, .data_in, .halt_n, .nop_force, .m1_n, .iorq_n, .svc_nmi,
    .vec_valid, .vector);

  // behavioural reference model
  bit m_nmi_prev, m_pend, m_ie, m_halt, m_svc, m_vv;
  int m_left;
  logic [7:0] m_vec;
  always @(posedge clk) begin
    bit pt, tn, ti;
    if (!rst_n) begin
      m_nmi_prev = 1; m_pend = 0; m_ie = 0; m_halt = 0;
      m_svc = 0; m_vv = 0; m_left = 0; m_vec = 0;
    end else begin
      pt = (instr_end || m_halt) && m_left == 0 && !bus_req;
      tn = pt && m_pend;
      ti = pt && !m_pend && !int_req_n && m_ie;
      m_svc = tn;
      m_vv = (m_left == 1);
      if (m_left == 1) m_vec = data_in;
      if (m_left > 0) m_left--;
      if (ti) m_left = ACK;
      m_pend = (m_nmi_prev && !nmi_n) || (m_pend && !tn);
      m_nmi_prev = nmi_n;
      if (tn || ti || ie_clr) m_ie = 0; else if (ie_set) m_ie = 1;
      if (tn || ti) m_halt = 0; else if (halt_exec) m_halt = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R7 halt_n", halt_n, !m_halt);
    chk("R7 nop_force", nop_force, m_halt);
    chk("R3 m1_n", m1_n, m_left == 0);
    chk("R3 iorq_n", iorq_n, m_left == 0);
    chk("R5 svc_nmi", svc_nmi, m_svc);
    chk("R4 vec_valid", vec_valid, m_vv);
    chk("R4 vector", vector, m_vec);
  end

  task automatic fin();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      fin();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic iend();
    instr_end = 1; step(1); instr_end = 0;
  endtask

  initial begin
    step(3);
    chk("R1 halt_n", halt_n, 1);
    chk("R1 m1_n", m1_n, 1);
    rst_n = 1;
    step(1);
    chk("R1 vector", vector, 0);
    // R2: disabled request ignored
    int_req_n = 0; iend();
    chk("R2 no ack when disabled", m1_n, 1);
    // R2: set and clear together -> clear wins
    ie_set = 1; ie_clr = 1; step(1); ie_set = 0; ie_clr = 0;
    iend();
    chk("R2 clear wins", m1_n, 1);
    ie_set = 1; step(1); ie_set = 0;
    data_in = 8'hA5; iend();
    chk("R3 ack start m1", m1_n, 0);
    chk("R3 ack start iorq", iorq_n, 0);
    step(ACK - 1);
    chk("R3 ack still low", m1_n, 0);
    step(1);
    chk("R4 vector latched", vector, 8'hA5);
    chk("R4 vec_valid", vec_valid, 1);
    data_in = 8'h3C;
    // R8: enable cleared by acceptance
    iend();
    chk("R8 second request ignored", m1_n, 1);
    chk("R4 vector held", vector, 8'hA5);
    int_req_n = 1;
    // R5: held NMI gives one pulse, priority, ignores enable
    nmi_n = 0; step(1); iend();
    chk("R5 nmi pulse", svc_nmi, 1);
    step(4); iend();
    chk("R5 no second pulse", svc_nmi, 0);
    nmi_n = 1; step(1);
    // R6: bus request defers
    ie_set = 1; step(1); ie_set = 0;
    nmi_n = 0; int_req_n = 0; step(1);
    bus_req = 1; iend();
    chk("R6 deferred nmi", svc_nmi, 0);
    chk("R6 deferred int", m1_n, 1);
    bus_req = 0; iend();
    chk("R5 nmi before int", svc_nmi, 1);
    chk("R5 no ack with nmi", m1_n, 1);
    nmi_n = 1; int_req_n = 1; step(2);
    // R7/R9: halt with enable clear stays halted
    halt_exec = 1; step(1); halt_exec = 0;
    chk("R7 halted", halt_n, 0);
    chk("R7 nop_force", nop_force, 1);
    int_req_n = 0; step(5);
    chk("R9 stays halted", halt_n, 0);
    chk("R9 no ack", m1_n, 1);
    ie_set = 1; step(1); ie_set = 0;
    step(1);
    chk("R7 released", halt_n, 1);
    chk("R7 ack from halt", m1_n, 0);
    int_req_n = 1; step(ACK + 2);
    // R7: NMI wakes halt
    halt_exec = 1; step(1); halt_exec = 0;
    nmi_n = 0; step(2);
    chk("R7 nmi wake pulse", svc_nmi, 1);
    chk("R7 nmi wake", halt_n, 1);
    nmi_n = 1;
    // R1: reset discards pending edge
    nmi_n = 0; step(1); rst_n = 0; step(2); rst_n = 1; nmi_n = 1;
    step(1); iend(); step(1);
    chk("R1 pending cleared", svc_nmi, 0);
    step(2);
    fin();
  end
endmodule